// File: doc/BRIEF.md
# Stack and Block Register Transfer Sequencer

This block carries out the 16-bit instruction set's stack push, stack pop, block load and block store instructions as a sequence of single-word memory transactions. The surrounding core raises `start` for one cycle with the instruction word and the value of the anchor register: the stack pointer for push and pop, or the base register selected by the instruction for block transfers. The sequencer then walks the register list from the lowest register upwards and issues one request per word on a valid/ready memory port. Registers to be stored are read through a register-file read port. Loaded words are returned through a register-file write port.

A ninth, optional slot in the list carries the link register on a push and the program counter on a pop. It is always transferred last, at the highest address. A push lowers the stack pointer before it stores anything. Every other form transfers upwards from the anchor and moves the anchor up afterwards. The updated anchor goes out on a writeback port in the cycle that `done` pulses. For a block transfer whose base register is itself in the list, that writeback is withheld.

Top module: `multi_xfer_seq`

## Requirements
- R1: A start is acted on only when bits 15:12 are 1011 and bits 10:9 are 10 (stack form, bit 11 set = pop, bit 8 = extra slot), or when bits 15:12 are 1100 (block form, bit 11 set = load, bits 10:8 = base register index). Any other word gives a `done` pulse one cycle after start, with no memory request, no register write, no PC load and no writeback.
- R2: The number of words moved equals the number of set bits in instruction bits 7:0, plus one when bit 8 is set in the stack form.
- R3: A push issues stores at ascending addresses starting at anchor minus 4 times the count. Listed registers go lowest index first, and the link register (index 14) goes last when bit 8 is set.
- R4: A pop issues loads at ascending addresses starting at the anchor and writes each listed register lowest first. When bit 8 is set, the last word goes out on `pc_data` with bit 0 cleared, qualified by `pc_load`, and not to the register-file write port.
- R5: On the `done` cycle of a push or pop with a non-empty list, `wb_en` is high with `wb_addr` = 13 and `wb_data` = anchor − 4×count for a push, or anchor + 4×count for a pop. The anchor is used unaligned here.
- R6: A block store or load transfers at ascending addresses from the base. When the base is not listed, it writes back base + 4×count to the base index on the `done` cycle.
- R7: A block transfer whose base register index has its bit set in the list gives no writeback (`wb_en` low on `done`). This applies to both loads and stores.
- R8: Bits 1:0 of every memory address are zero, whatever the low bits of the anchor.
- R9: While `mem_req` is high and `mem_ready` is low, the request, address and direction are held unchanged in the next cycle.
- R10: A recognised instruction with an empty list (count 0) gives `done` one cycle after start, with no memory request and no writeback.
- R11: `busy` is high from the cycle after start until the cycle in which the last word is accepted. `done` is a single-cycle pulse in the cycle after that acceptance, and `busy` and `done` are never high together.
- R12: A start raised while `busy` is high has no effect on the transfer in progress, and does not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| instr | input | 16 | Instruction word |
| anchor | input | DW | Stack pointer or base register value |
| rf_raddr | output | 4 | Register-file read index for stores |
| rf_rdata | input | DW | Register-file read data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | DW | Word-aligned byte address |
| mem_wdata | output | DW | Store data |
| mem_ready | input | 1 | Memory accepts/completes the request |
| mem_rdata | input | DW | Load data, valid with `mem_ready` |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | DW | Register-file write data |
| pc_load | output | 1 | Load program counter from pop |
| pc_data | output | DW | New program counter, bit 0 cleared |
| wb_en | output | 1 | Anchor writeback enable |
| wb_addr | output | 4 | Writeback register index |
| wb_data | output | DW | Writeback value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a memory stall in the middle of a long list, especially on the slot that carries the link register or program counter. The stall must land while the next register index is being chosen, so that any slip in the held address or index shows up. The bench's memory model therefore withholds `mem_ready` on a pseudo-random pattern throughout every run, and full nine-slot pushes and pops are included. The bench also keeps `start` raised with a different instruction during a long push, to show that the extra start is ignored. It uses unaligned stack pointers and base-in-list block transfers to reach the alignment and writeback-suppression corners.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_END  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic       valid;     // recognised stack or block form
    logic       load;      // words flow memory -> registers
    logic       predec;    // lower the anchor before transferring
    logic       keep_base; // base listed: no writeback
    logic [8:0] slots;     // bit 8 = link/pc extra slot
    logic [3:0] base;      // anchor register index
    logic [3:0] count;     // words to move
  } xfer_dec_t;

endpackage

// File: rtl/mxs_decode.sv
module mxs_decode
  import mxs_pkg::*;
(
  input  logic [15:0] instr,
  output xfer_dec_t   dec
);

  logic is_stack;
  logic is_block;
  logic [8:0] slots;
  logic [3:0] ones;

  assign is_stack = (instr[15:12] == 4'hB) && (instr[10:9] == 2'b10);
  assign is_block = (instr[15:12] == 4'hC);
  assign slots    = is_stack ? instr[8:0] : {1'b0, instr[7:0]};

  always_comb begin
    ones = 4'd0;
    for (int i = 0; i < 9; i++) begin
      ones = ones + {3'd0, slots[i]};
    end
  end

  always_comb begin
    dec.valid     = is_stack | is_block;
    dec.load      = instr[11];
    dec.predec    = is_stack & ~instr[11];
    dec.keep_base = is_block & instr[instr[10:8]];
    dec.slots     = slots;
    dec.base      = is_stack ? 4'd13 : {1'b0, instr[10:8]};
    dec.count     = ones;
  end

endmodule

// File: rtl/mxs_pick.sv
module mxs_pick #(
  parameter int SLOTS = 9,
  localparam int IW = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0] pending,
  output logic [SLOTS-1:0] first_oh,
  output logic [IW-1:0]    first_idx
);

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_oh
      if (g == 0) begin : g_lsb
        assign first_oh[g] = pending[g];
      end else begin : g_up
        assign first_oh[g] = pending[g] & ~(|pending[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    first_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (first_oh[i]) first_idx = first_idx | IW'(i);
    end
  end

endmodule

// File: rtl/mxs_span.sv
module mxs_span #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] anchor,
  input  logic [3:0]    count,
  input  logic          predec,
  output logic [DW-1:0] first_addr,
  output logic [DW-1:0] new_anchor
);

  logic [DW-1:0] bytes;
  logic [DW-1:0] lowered;
  logic [DW-1:0] raised;

  assign bytes   = {{(DW-6){1'b0}}, count, 2'b00};
  assign lowered = anchor - bytes;
  assign raised  = anchor + bytes;

  assign first_addr = predec ? {lowered[DW-1:2], 2'b00} : {anchor[DW-1:2], 2'b00};
  assign new_anchor = predec ? lowered : raised;

endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import mxs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  input  logic [DW-1:0] anchor,
  output logic [3:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_we,
  output logic [3:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          pc_load,
  output logic [DW-1:0] pc_data,
  output logic          wb_en,
  output logic [3:0]    wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          busy,
  output logic          done
);

  localparam int SLOTS = 9;
  localparam int XSLOT = SLOTS - 1;
  localparam int STEP  = DW / 8;

  xfer_dec_t     dec;
  logic [DW-1:0] span_first;
  logic [DW-1:0] span_new;
  logic [SLOTS-1:0] pick_oh;
  logic [3:0]    pick_idx;

  seq_state_e    state_q, state_d;
  logic [SLOTS-1:0] pend_q, pend_d;
  logic [DW-1:0] addr_q, addr_d;
  logic          load_q, load_d;
  logic [DW-1:0] wbv_q, wbv_d;
  logic [3:0]    wbi_q, wbi_d;
  logic          wbok_q, wbok_d;
  logic          take;
  logic          accept;
  logic          extra_slot;

  mxs_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  mxs_span #(.DW(DW)) u_span (
    .anchor     (anchor),
    .count      (dec.count),
    .predec     (dec.predec),
    .first_addr (span_first),
    .new_anchor (span_new)
  );

  mxs_pick #(.SLOTS(SLOTS)) u_pick (
    .pending   (pend_q),
    .first_oh  (pick_oh),
    .first_idx (pick_idx)
  );

  assign take       = (state_q == ST_IDLE) && start;
  assign accept     = (state_q == ST_MOVE) && mem_ready;
  assign extra_slot = (pick_idx == 4'(XSLOT));

  // next-state process
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    addr_d  = addr_q;
    load_d  = load_q;
    wbv_d   = wbv_q;
    wbi_d   = wbi_q;
    wbok_d  = wbok_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          wbok_d = 1'b0;
          if (dec.valid && (dec.count != 4'd0)) begin
            state_d = ST_MOVE;
            pend_d  = dec.slots;
            addr_d  = span_first;
            load_d  = dec.load;
            wbv_d   = span_new;
            wbi_d   = dec.base;
            wbok_d  = ~dec.keep_base;
          end else begin
            state_d = ST_END;
          end
        end
      end
      ST_MOVE: begin
        if (mem_ready) begin
          pend_d = pend_q & ~pick_oh;
          addr_d = addr_q + DW'(STEP);
          if ((pend_q & ~pick_oh) == '0) state_d = ST_END;
        end
      end
      ST_END: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      load_q  <= 1'b0;
      wbv_q   <= '0;
      wbi_q   <= '0;
      wbok_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take || accept) begin
        pend_q <= pend_d;
        addr_q <= addr_d;
      end
      if (take) begin
        load_q <= load_d;
        wbv_q  <= wbv_d;
        wbi_q  <= wbi_d;
        wbok_q <= wbok_d;
      end
    end
  end

  assign busy      = (state_q == ST_MOVE);
  assign done      = (state_q == ST_END);

  assign mem_req   = busy;
  assign mem_we    = busy & ~load_q;
  assign mem_addr  = addr_q;
  assign rf_raddr  = extra_slot ? 4'd14 : pick_idx;
  assign mem_wdata = rf_rdata;

  assign rf_we     = accept & load_q & ~extra_slot;
  assign rf_waddr  = pick_idx;
  assign rf_wdata  = mem_rdata;
  assign pc_load   = accept & load_q & extra_slot;
  assign pc_data   = mem_rdata & ~DW'(1);

  assign wb_en     = done & wbok_q;
  assign wb_addr   = wbi_q;
  assign wb_data   = wbv_q;

endmodule

// File: rtl/multi_xfer_seq_chk.sv
module multi_xfer_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          pc_load,
  input logic [DW-1:0] pc_data,
  input logic          rf_we,
  input logic          wb_en,
  input logic          busy,
  input logic          done
);

  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + DW'(4))));

  p_pc_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> !pc_data[0]);

  p_rf_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || pc_load) |-> (mem_req && mem_ready && !mem_we));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_wb_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

endmodule

bind multi_xfer_seq multi_xfer_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/multi_xfer_seq_test.sv
module multi_xfer_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  typedef struct {
    logic          we;
    logic [DW-1:0] addr;
    logic [DW-1:0] data;
  } mem_item_t;

  typedef struct {
    logic [3:0]    idx;   // 15 = program counter load
    logic [DW-1:0] data;
  } wr_item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [15:0]   instr;
  logic [DW-1:0] anchor;
  logic [3:0]    rf_raddr;
  logic [DW-1:0] rf_rdata;
  logic          mem_req, mem_we, mem_ready;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
  logic          rf_we, pc_load, wb_en, busy, done;
  logic [3:0]    rf_waddr, wb_addr;
  logic [DW-1:0] rf_wdata, pc_data, wb_data;

  logic [DW-1:0] regs [16];
  logic [DW-1:0] mem_arr [64];
  mem_item_t     mem_q [$];
  wr_item_t      wr_q [$];
  int            checks = 0;
  int            errors = 0;
  int            cycles = 0;
  logic [7:0]    lfsr = 8'h5A;
  logic          stalled = 1'b0;
  logic [DW-1:0] stall_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem_arr[mem_addr[7:2]];

  multi_xfer_seq #(.DW(DW)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 50000);
      finish_run();
    end
  end

  // monitor: memory model, ready pattern, scoreboard compare
  always begin
    @(negedge clk);
    if (rst_n) begin
      if (stalled) begin
        chk(mem_req && mem_addr == stall_addr, "R9", "held address",
            mem_addr, stall_addr);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = mem_req && (lfsr[0] | lfsr[2]);
      stalled = mem_req && !mem_ready;
      stall_addr = mem_addr;
      #1;
      if (mem_req && mem_ready) begin
        if (mem_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected memory transfer", mem_addr, '0);
        end else begin
          mem_item_t e;
          e = mem_q.pop_front();
          chk(mem_addr == e.addr, "R3", "address", mem_addr, e.addr);
          chk(mem_we == e.we, "R6", "direction", {31'd0, mem_we}, {31'd0, e.we});
          if (e.we) begin
            chk(mem_wdata == e.data, "R3", "store data", mem_wdata, e.data);
            mem_arr[mem_addr[7:2]] = mem_wdata;
          end
        end
      end
      if (rf_we || pc_load) begin
        if (wr_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected register write", rf_wdata, '0);
        end else begin
          wr_item_t w;
          w = wr_q.pop_front();
          if (w.idx == 4'd15) begin
            chk(pc_load && !rf_we, "R4", "pc slot port", {31'd0, pc_load}, 1);
            chk(pc_data == w.data, "R4", "pc value", pc_data, w.data);
          end else begin
            chk(rf_we && rf_waddr == w.idx, "R4", "write index",
                {28'd0, rf_waddr}, {28'd0, w.idx});
            chk(rf_wdata == w.data, "R4", "write data", rf_wdata, w.data);
            regs[rf_waddr] = rf_wdata;
          end
        end
      end
    end else begin
      mem_ready = 1'b0;
    end
  end

  // driver: predicts the transfer, pushes expectations, runs the instruction
  task automatic run_op(input logic [15:0] ins, input string req, input bit poke);
    bit            is_stack, is_block, valid, ld, predec, wb_exp;
    logic [8:0]    slots;
    logic [3:0]    base;
    int            n;
    logic [DW-1:0] anc, a, wbv;
    int            guard;
    is_stack = (ins[15:12] == 4'hB) && (ins[10:9] == 2'b10);
    is_block = (ins[15:12] == 4'hC);
    valid    = is_stack || is_block;
    ld       = ins[11];
    predec   = is_stack && !ld;
    slots    = is_stack ? ins[8:0] : {1'b0, ins[7:0]};
    base     = is_stack ? 4'd13 : {1'b0, ins[10:8]};
    n = 0;
    for (int i = 0; i < 9; i++) if (slots[i]) n++;
    anc = regs[base];
    wbv = predec ? anc - DW'(4*n) : anc + DW'(4*n);
    wb_exp = valid && (n > 0) && !(is_block && ins[ins[10:8]]);
    if (valid && n > 0) begin
      a = predec ? anc - DW'(4*n) : anc;
      a[1:0] = 2'b00;
      for (int i = 0; i < 9; i++) begin
        if (slots[i]) begin
          if (ld) begin
            mem_q.push_back('{1'b0, a, mem_arr[a[7:2]]});
            if (i == 8) wr_q.push_back('{4'd15, mem_arr[a[7:2]] & ~DW'(1)});
            else        wr_q.push_back('{4'(i), mem_arr[a[7:2]]});
          end else begin
            mem_q.push_back('{1'b1, a, regs[(i == 8) ? 14 : i]});
          end
          a = a + DW'(4);
        end
      end
    end
    @(negedge clk);
    instr  = ins;
    anchor = anc;
    start  = 1'b1;
    @(negedge clk);
    if (valid && n > 0) begin
      chk(busy && !done, "R11", "busy after start", {31'd0, busy}, 1);
    end else begin
      chk(done && !busy && !mem_req && !wb_en, "R10", "immediate done, no traffic",
          {28'd0, done, busy, mem_req, wb_en}, 32'h8);
      if (!valid) chk(done, "R1", "unrecognised word completes", {31'd0, done}, 1);
    end
    guard = 0;
    while (!done && guard < 2000) begin
      if (poke) begin
        start  = 1'b1;
        instr  = 16'hBC01;
        anchor = 32'h0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk(done, "R11", "done reached", {31'd0, done}, 1);
    chk(mem_q.size() == 0 && wr_q.size() == 0, (n > 0) ? "R2" : "R10",
        "all words moved before done", DW'(mem_q.size() + wr_q.size()), 0);
    chk(wb_en == wb_exp, is_block ? "R7" : "R5", "writeback enable",
        {31'd0, wb_en}, {31'd0, wb_exp});
    if (wb_exp) begin
      chk(wb_addr == base && wb_data == wbv, is_block ? "R6" : "R5",
          "writeback value", wb_data, wbv);
      regs[base] = wb_data;
    end
    @(negedge clk);
    chk(!done && !busy, "R11", "done is one pulse", {30'd0, done, busy}, 0);
    if (poke) chk(!mem_req, "R12", "no second run started", {31'd0, mem_req}, 0);
    $display("ran %h for %s", ins, req);
  endtask

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    instr  = 16'h0;
    anchor = '0;
    mem_ready = 1'b0;
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + DW'(i * 32'h111);
    for (int i = 0; i < 64; i++) mem_arr[i] = 32'hA000_0001 + DW'(i * 7);
    regs[13] = 32'h80;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !wb_en, "R11", "reset state",
        {28'd0, busy, done, mem_req, wb_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(16'hB425, "R3 push r0 r2 r5", 1'b0);
    run_op(16'hB582, "R3 push r1 r7 lr", 1'b0);
    run_op(16'hBD82, "R4 pop r1 r7 pc", 1'b0);
    run_op(16'hBC25, "R4 pop r0 r2 r5", 1'b0);
    regs[13] = 32'h63;
    run_op(16'hB408, "R8 push unaligned sp", 1'b0);
    run_op(16'hBC08, "R8 pop unaligned sp", 1'b0);
    regs[1] = 32'h41;
    run_op(16'hC119, "R6 block store", 1'b0);
    regs[1] = 32'h40;
    run_op(16'hC919, "R6 block load", 1'b0);
    regs[2] = 32'h20;
    run_op(16'hCA0F, "R7 block load base listed", 1'b0);
    regs[2] = 32'h30;
    run_op(16'hC205, "R7 block store base listed", 1'b0);
    run_op(16'hB400, "R10 empty push", 1'b0);
    run_op(16'hC800, "R10 empty block load", 1'b0);
    run_op(16'h4000, "R1 other class", 1'b0);
    run_op(16'hB203, "R1 stack form bad bits", 1'b0);
    regs[13] = 32'hC0;
    run_op(16'hB5FF, "R12 full push with start held", 1'b1);
    run_op(16'hBDFF, "R2 full pop", 1'b0);

    finish_run();
  end

endmodule